// File: doc/BRIEF.md
# Reciprocal Frequency Counter

This block measures the frequency of an asynchronous digital input with the reciprocal method. After a start strobe it waits for a rising edge on the input. That edge opens a gate. While the gate is open, the block counts two things over the same interval: the input periods, and the system clocks. The gate closes on a later rising edge, the first one that arrives once a programmable minimum gate time has passed. Because the gate opens and closes only on qualified rising edges, both counts cover an exact whole number of input periods.

Software works out the frequency as the period count divided by the clock count, times the clock rate. The block does not divide and does not average. The input goes through a single sampling flop and then one history flop, and edges are detected in the clock domain. The input must toggle slower than the system clock; faster edges alias.

Top module: `recip_freq_meter`

## Requirements
- R1: While reset is held and right after it is released, `period_cnt_o`, `clock_cnt_o`, `span_ovf_o` and `meas_done_o` are all zero.
- R2: A rising edge is a sampled input that was low in the previous clock and is high in the current one. Falling edges and the input duty cycle have no effect on either count.
- R3: A rising edge starts a measurement only after a `start_i` pulse. Without a new `start_i`, `meas_done_o` stays low and the captured outputs hold their values.
- R4: The gate closes on the first rising edge at which the clocks elapsed since the opening edge are at least `min_gate_clks`. For an input of P clocks per period, `period_cnt_o` is N = max(1, ceil(min_gate_clks / P)) and `clock_cnt_o` is N*P.
- R5: A `min_gate_clks` of 0 or 1 measures exactly one input period.
- R6: `meas_done_o` is high for exactly one clock per measurement. The captured outputs change only in the cycle where `meas_done_o` is high.
- R7: If the clock count would pass the all-ones value of CNT_W bits, it saturates there and `span_ovf_o` is reported high with the result. The next measurement that does not saturate reports it low.
- R8: A `start_i` pulse during a measurement abandons it and re-arms the block. The gate then reopens on the next rising edge, and the minimum gate time is counted again from that edge.
- R9: The counter width is the parameter CNT_W (default 32). All count ports and `min_gate_clks` are CNT_W bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | 1 | Asynchronous input to measure |
| min_gate_clks | input | CNT_W | Minimum gate time, in clocks |
| start_i | input | 1 | Pulse that arms a measurement |
| period_cnt_o | output | CNT_W | Whole input periods in the last gate |
| clock_cnt_o | output | CNT_W | System clocks in the last gate |
| span_ovf_o | output | 1 | Clock count saturated in the last gate |
| meas_done_o | output | 1 | One-clock pulse when new counts are captured |

## Verification
If the gate opened or closed on the wrong edge, the clock count would stop being an exact multiple of the input period. This shows in the first result after the fault. A wrong threshold comparison shows up as an extra or missing period. It is most visible when the minimum gate is an exact multiple of the period. A stuck gate state shows within one measurement window in one of two ways: as a missing done pulse, or as a done pulse without any start. If the saturation flag is not cleared, the first short measurement after an overflow reports it.

// File: rtl/rfm_pkg.sv
package rfm_pkg;
  typedef enum logic [1:0] {
    GS_IDLE  = 2'd0,
    GS_ARMED = 2'd1,
    GS_OPEN  = 2'd2
  } gate_state_e;
endpackage

// File: rtl/rfm_pin_sync.sv
// One sampling flop from the asynchronous input, one history flop, rise detect.
module rfm_pin_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o
);
  logic samp_q;
  logic hist_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      samp_q <= 1'b0;
      hist_q <= 1'b0;
    end else begin
      samp_q <= pin_i;
      hist_q <= samp_q;
    end
  end

  assign rise_o = samp_q & ~hist_q;
endmodule

// File: rtl/rfm_gate_ctl.sv
// Gate sequencing: idle, armed, open.
module rfm_gate_ctl
  import rfm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic rise_i,
  input  logic span_met_i,
  output logic open_evt_o,
  output logic close_evt_o,
  output logic gate_open_o
);
  gate_state_e st_q, st_d;

  assign open_evt_o  = (st_q == GS_ARMED) && rise_i && !start_i;
  assign close_evt_o = (st_q == GS_OPEN) && rise_i && span_met_i && !start_i;
  assign gate_open_o = (st_q == GS_OPEN);

  always_comb begin
    st_d = st_q;
    if (start_i)          st_d = GS_ARMED;
    else if (open_evt_o)  st_d = GS_OPEN;
    else if (close_evt_o) st_d = GS_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= GS_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/rfm_span_cnt.sv
// Running clock and period counters over the open gate.
module rfm_span_cnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_i,
  input  logic             gate_i,
  input  logic             rise_i,
  input  logic [CNT_W-1:0] min_gate_i,
  output logic [CNT_W-1:0] clk_run_o,
  output logic [CNT_W-1:0] per_run_o,
  output logic             sat_o,
  output logic             span_met_o
);
  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE      = {{(CNT_W-1){1'b0}}, 1'b1};

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == ALL_ONES) ? v : v + ONE;
  endfunction

  function automatic logic span_reached(input logic [CNT_W-1:0] elapsed,
                                        input logic [CNT_W-1:0] floor_clks);
    return elapsed >= floor_clks;
  endfunction

  logic [CNT_W-1:0] clk_q, per_q;
  logic             sat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_q <= '0;
      per_q <= '0;
      sat_q <= 1'b0;
    end else if (open_i) begin
      clk_q <= ONE;
      per_q <= '0;
      sat_q <= 1'b0;
    end else if (gate_i) begin
      clk_q <= sat_inc(clk_q);
      if (clk_q == ALL_ONES) sat_q <= 1'b1;
      if (rise_i) per_q <= sat_inc(per_q);
    end
  end

  assign clk_run_o  = clk_q;
  assign per_run_o  = per_q;
  assign sat_o      = sat_q;
  assign span_met_o = span_reached(clk_q, min_gate_i);
endmodule

// File: rtl/rfm_capture.sv
// Latches the counts on the closing edge and pulses done.
module rfm_capture #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             close_i,
  input  logic [CNT_W-1:0] clk_run_i,
  input  logic [CNT_W-1:0] per_run_i,
  input  logic             sat_i,
  output logic [CNT_W-1:0] clocks_o,
  output logic [CNT_W-1:0] periods_o,
  output logic             ovf_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE      = {{(CNT_W-1){1'b0}}, 1'b1};

  // the closing edge ends one more period than the running count holds
  function automatic logic [CNT_W-1:0] closing_periods(input logic [CNT_W-1:0] v);
    return (v == ALL_ONES) ? v : v + ONE;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clocks_o  <= '0;
      periods_o <= '0;
      ovf_o     <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      done_o <= close_i;
      if (close_i) begin
        clocks_o  <= clk_run_i;
        periods_o <= closing_periods(per_run_i);
        ovf_o     <= sat_i;
      end
    end
  end
endmodule

// File: rtl/recip_freq_meter.sv
module recip_freq_meter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_i,
  input  logic [CNT_W-1:0] min_gate_clks,
  input  logic             start_i,
  output logic [CNT_W-1:0] period_cnt_o,
  output logic [CNT_W-1:0] clock_cnt_o,
  output logic             span_ovf_o,
  output logic             meas_done_o
);
  logic             rise_w;
  logic             open_evt_w;
  logic             close_evt_w;
  logic             gate_open_w;
  logic             span_met_w;
  logic             sat_w;
  logic [CNT_W-1:0] clk_run_w;
  logic [CNT_W-1:0] per_run_w;

  rfm_pin_sync u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .rise_o(rise_w)
  );

  rfm_gate_ctl u_gate (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rise_i(rise_w),
    .span_met_i(span_met_w), .open_evt_o(open_evt_w),
    .close_evt_o(close_evt_w), .gate_open_o(gate_open_w)
  );

  rfm_span_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .open_i(open_evt_w), .gate_i(gate_open_w),
    .rise_i(rise_w), .min_gate_i(min_gate_clks), .clk_run_o(clk_run_w),
    .per_run_o(per_run_w), .sat_o(sat_w), .span_met_o(span_met_w)
  );

  rfm_capture #(.CNT_W(CNT_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .close_i(close_evt_w), .clk_run_i(clk_run_w),
    .per_run_i(per_run_w), .sat_i(sat_w), .clocks_o(clock_cnt_o),
    .periods_o(period_cnt_o), .ovf_o(span_ovf_o), .done_o(meas_done_o)
  );
endmodule

// File: rtl/rfm_chk.sv
module rfm_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rise_w,
  input logic             close_evt_w,
  input logic             gate_open_w,
  input logic [CNT_W-1:0] min_gate_clks,
  input logic [CNT_W-1:0] period_cnt_o,
  input logic [CNT_W-1:0] clock_cnt_o,
  input logic             span_ovf_o,
  input logic             meas_done_o
);
  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    meas_done_o |=> !meas_done_o);

  // R6
  hold_clocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_done_o |-> $stable(clock_cnt_o) && $stable(period_cnt_o) && $stable(span_ovf_o));

  // R4
  close_to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    close_evt_w |=> meas_done_o);

  // R2
  close_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    close_evt_w |-> rise_w && gate_open_w);

  // R4
  whole_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    meas_done_o |-> period_cnt_o != '0 && clock_cnt_o >= period_cnt_o);

  // R4
  min_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    meas_done_o && !span_ovf_o |-> clock_cnt_o >= $past(min_gate_clks));

  // R7
  sat_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    meas_done_o && span_ovf_o |-> clock_cnt_o == {CNT_W{1'b1}});
endmodule

bind recip_freq_meter rfm_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .rise_w(rise_w), .close_evt_w(close_evt_w),
  .gate_open_w(gate_open_w), .min_gate_clks(min_gate_clks),
  .period_cnt_o(period_cnt_o), .clock_cnt_o(clock_cnt_o),
  .span_ovf_o(span_ovf_o), .meas_done_o(meas_done_o)
);

// File: tb/recip_freq_meter_tb_top.sv
`timescale 1ns/1ps
module recip_freq_meter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin = 1'b0;
  logic start_a = 1'b0, start_b = 1'b0;
  logic [31:0] min_a = '0;
  logic [7:0]  min_b = '0;
  logic [31:0] per_a, clk_a;
  logic [7:0]  per_b, clk_b;
  logic ovf_a, ovf_b, done_a, done_b;

  int unsigned n_run = 0, n_fail = 0, ncyc = 0;
  int unsigned wave_per = 10, wave_hi = 5, ph = 0;

  always #4 clk = ~clk;

  recip_freq_meter dut_i (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .min_gate_clks(min_a),
    .start_i(start_a), .period_cnt_o(per_a), .clock_cnt_o(clk_a),
    .span_ovf_o(ovf_a), .meas_done_o(done_a)
  );

  recip_freq_meter #(.CNT_W(8)) small_i (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .min_gate_clks(min_b),
    .start_i(start_b), .period_cnt_o(per_b), .clock_cnt_o(clk_b),
    .span_ovf_o(ovf_b), .meas_done_o(done_b)
  );

  // periodic input, changed only on falling clock edges
  always @(negedge clk) begin
    pin = (ph < wave_hi);
    ph  = (ph + 1 >= wave_per) ? 0 : ph + 1;
  end

  task automatic summary_and_end();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    ncyc++;
    if (ncyc > 150000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", ncyc);
      summary_and_end();
    end
  end

  function automatic int unsigned exp_periods(int unsigned p, int unsigned m);
    if (m <= p) return 1;
    return (m + p - 1) / p;
  endfunction

  task automatic check(string req, longint act, longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_wave(int unsigned p, int unsigned h);
    @(negedge clk);
    wave_per = p; wave_hi = h; ph = 0;
    repeat (2 * p + 4) @(negedge clk);
  endtask

  // run one measurement on the wide instance and check it
  task automatic measure_a(string req, int unsigned m);
    int unsigned n, waited, hi_cnt;
    min_a = m;
    @(negedge clk); start_a = 1'b1;
    @(negedge clk); start_a = 1'b0;
    waited = 0;
    while (!done_a && waited < 20000) begin @(negedge clk); waited++; end
    n = exp_periods(wave_per, m);
    check({req, " done seen"}, done_a, 1);
    check({req, " periods"}, per_a, n);
    check({req, " clocks"}, clk_a, n * wave_per);
    check({req, " ovf"}, ovf_a, 0);
    hi_cnt = 0;
    @(negedge clk); if (done_a) hi_cnt++;
    check("R6 single pulse", hi_cnt, 0);
  endtask

  initial begin
    int unsigned seen, saved_p, saved_c, waited;
    repeat (3) @(negedge clk);
    check("R1 periods", per_a, 0);
    check("R1 clocks", clk_a, 0);
    check("R1 ovf/done", {ovf_a, done_a}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {per_a, clk_a, ovf_a, done_a}, 0);

    set_wave(10, 5);
    measure_a("R5 min0", 0);
    measure_a("R5 min1", 1);
    measure_a("R4 exact multiple", 30);
    measure_a("R4 one over", 31);

    set_wave(12, 1);
    measure_a("R2 narrow high", 40);
    set_wave(12, 11);
    measure_a("R2 wide high", 40);

    // R3: no start, no done, outputs held
    saved_p = per_a; saved_c = clk_a; seen = 0;
    repeat (200) begin @(negedge clk); if (done_a) seen++; end
    check("R3 no done without start", seen, 0);
    check("R3 periods held", per_a, saved_p);
    check("R3 clocks held", clk_a, saved_c);

    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 12; i++) begin
      int unsigned p, h;
      p = 2 + ($urandom % 39);
      h = 1 + ($urandom % (p - 1));
      set_wave(p, h);
      measure_a("R4 random", $urandom % 201);
    end

    // R8: restart mid-measurement
    set_wave(10, 5);
    min_a = 1000;
    @(negedge clk); start_a = 1'b1;
    @(negedge clk); start_a = 1'b0;
    seen = 0;
    repeat (300) begin @(negedge clk); if (done_a) seen++; end
    check("R8 no early done", seen, 0);
    @(negedge clk); start_a = 1'b1;
    @(negedge clk); start_a = 1'b0;
    waited = 0;
    while (!done_a && waited < 5000) begin @(negedge clk); waited++; end
    check("R8 done after restart", done_a, 1);
    check("R8 full gate after restart", waited >= 1000, 1);
    check("R8 periods", per_a, 100);
    check("R8 clocks", clk_a, 1000);

    // R7: saturation on the 8-bit instance
    set_wave(300, 150);
    min_b = 8'd10;
    @(negedge clk); start_b = 1'b1;
    @(negedge clk); start_b = 1'b0;
    waited = 0;
    while (!done_b && waited < 2000) begin @(negedge clk); waited++; end
    check("R7 done", done_b, 1);
    check("R7 saturated clocks", clk_b, 255);
    check("R7 ovf set", ovf_b, 1);
    check("R7 periods", per_b, 1);

    set_wave(20, 7);
    min_b = 8'd50;
    @(negedge clk); start_b = 1'b1;
    @(negedge clk); start_b = 1'b0;
    waited = 0;
    while (!done_b && waited < 2000) begin @(negedge clk); waited++; end
    check("R7 R9 periods narrow", per_b, 3);
    check("R7 R9 clocks narrow", clk_b, 60);
    check("R7 ovf cleared", ovf_b, 0);

    summary_and_end();
  end
endmodule